// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable model of a synchronous static RAM that accepts one read or one write on every rising clock edge. It needs no idle cycle when traffic changes direction. All commands, addresses and byte enables are captured at the clock edge. Write data follows its address by a fixed latency, so the block keeps issued writes in a short internal pipeline until their data arrives. A read that targets a word whose write is still in flight returns the new bytes merged over the stored word.

A static mode pin selects one of two timings. In pipelined mode, read data passes through an output register, and write data trails its address by two edges. In flow-through mode, read data comes straight from the array during the access cycle, and write data trails by one edge. A burst-order pin selects linear or XOR (interleaved) sequencing for four-beat bursts. An advance input continues a burst that a load cycle started.

Data in and data out use separate ports, and a drive flag replaces a tri-state bus. An output-enable pin and a sleep pin both turn the drive flag off asynchronously. Sleep also blocks new commands.

Top module: `nbt_sram`

## Requirements
- R1: While `rst` is high and after it falls, `rdrive` is low and no command is pending. Synchronous reset does not clear the stored words.
- R2: In pipelined mode (`flow_mode`=0), a read captured at edge n drives its word with `rdrive`=1 from edge n+1 until edge n+2.
- R3: In flow-through mode (`flow_mode`=1), a read captured at edge n drives its word with `rdrive`=1 from just after edge n until edge n+1.
- R4: A write captured at edge n takes `wdata` at edge n+2 in pipelined mode and at edge n+1 in flow-through mode. Data present at any other edge is not stored.
- R5: Reads and writes may follow each other on consecutive edges in any order. A pipelined read issued right after a write to the same word returns that write's data.
- R6: `ben[i]`=1 writes lane i, which is bits [9i+8:9i]. Lanes with `ben[i]`=0 keep their stored value. A forwarded read merges the pending lanes over the stored word.
- R7: A load cycle (`adv`=0) is a command only when `en0_n`=0, `en1`=1 and `en2_n`=0. Otherwise the cycle does nothing and any burst ends.
- R8: With `ilv_order`=0, each advance cycle (`adv`=1) after a load accesses the same upper address. Its two low bits are (start + k) mod 4 for beat k, and the sequence wraps after four beats.
- R9: With `ilv_order`=1, beat k accesses the low bits start XOR k.
- R10: On advance cycles, the direction of the load command is kept. The `wr`, `addr` and chip-enable inputs are ignored.
- R11: `oe_n`=1 forces `rdrive` low at once, without waiting for a clock edge. Releasing it restores the pending read data within the same cycle.
- R12: While `sleep`=1, `rdrive` is low and commands (loads and advances) are ignored. Stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flow_mode | input | 1 | Static: 0 pipelined, 1 flow-through |
| ilv_order | input | 1 | Burst order: 0 linear, 1 XOR |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 continues the burst, 0 loads a new command |
| wr | input | 1 | Load direction: 1 write, 0 read |
| addr | input | 6 | Word address |
| ben | input | 4 | Byte-lane write enables, active high |
| wdata | input | 36 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down |
| rdata | output | 36 | Read data, zero while not driving |
| rdrive | output | 1 | Read data valid and driven |

## Verification
Isolated writes and reads in each mode show the read latency and which edge the write data is taken from. Decoy data on the other edges exposes a write taken at the wrong edge. Back-to-back write-then-read to the same word, with full and partial byte enables, separates correct forwarding and lane merging from a stale array read. Bursts started at a low address of 01 give different address sequences in linear and XOR order, and they also cover the wrap after four beats. During advance beats the bench drives the opposite direction and a foreign address. Deselect patterns on each of the three enables, and the output-enable and sleep pins, are checked at the data ports.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  ben;
    } cmd_t;

    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] k,
        input order_e            ord
    );
        return (ord == ORD_XOR) ? (start ^ k) : (start + k);
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] upd,
        input logic [LANES-1:0]  ben
    );
        logic [DATA_W-1:0] res;
        res = base;
        for (int i = 0; i < LANES; i++) begin
            if (ben[i]) res[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction
endpackage

// File: rtl/nbt_cmd_gen.sv
module nbt_cmd_gen
    import nbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              ilv,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic              adv,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  ben,
    output cmd_t              cmd
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              live;
    logic              dir;
    logic [HI_W-1:0]   base_hi;
    logic [BEAT_W-1:0] start_lo;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] nxt_beat;
    logic              selected;

    always_comb begin
        selected = !en0_n && en1 && !en2_n;
        nxt_beat = beat + 1'b1;
        cmd      = '0;
        if (!sleep) begin
            if (adv) begin
                cmd.vld  = live;
                cmd.wr   = dir;
                cmd.addr = {base_hi, beat_low(start_lo, nxt_beat, order_e'(ilv))};
                cmd.ben  = ben;
            end else begin
                cmd.vld  = selected;
                cmd.wr   = wr;
                cmd.addr = addr;
                cmd.ben  = ben;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live     <= 1'b0;
            dir      <= 1'b0;
            base_hi  <= '0;
            start_lo <= '0;
            beat     <= '0;
        end else if (sleep) begin
            live <= 1'b0;
        end else if (adv) begin
            beat <= nxt_beat;
        end else begin
            live     <= selected;
            dir      <= wr;
            base_hi  <= addr[ADDR_W-1:BEAT_W];
            start_lo <= addr[BEAT_W-1:0];
            beat     <= '0;
        end
    end

    AST_BURST_KEEPS_ROW: assert property (@(posedge clk) disable iff (rst)
        (adv && live && !sleep) |-> (cmd.wr == $past(cmd.wr) &&
            cmd.addr[ADDR_W-1:BEAT_W] == $past(cmd.addr[ADDR_W-1:BEAT_W]))); // R10
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && live && !sleep && !ilv) |->
            (cmd.addr[BEAT_W-1:0] == BEAT_W'($past(cmd.addr[BEAT_W-1:0]) + 1'b1))); // R8
    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && live && !sleep && ilv) |-> (cmd.addr[0] != $past(cmd.addr[0]))); // R9
    AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (!adv && !sleep && (en0_n || !en1 || en2_n)) |=> !live); // R7
endmodule

// File: rtl/nbt_array.sv
module nbt_array
    import nbt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LN = LANES,
    parameter int LW = LANE_W
) (
    input  logic           clk,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [LN-1:0]  wben,
    input  logic [LN*LW-1:0] wdata,
    input  logic [AW-1:0]  raddr,
    output logic [LN*LW-1:0] rword
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LN; g++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wben[g]) cells[waddr] <= wdata[g*LW +: LW];
        end
        assign rword[g*LW +: LW] = cells[raddr];
    end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
    import nbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_mode,
    input  logic              ilv_order,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic              adv,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  ben,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rdrive
);
    cmd_t              cmd;
    cmd_t              s1;
    cmd_t              s2;
    cmd_t              wstage;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] fwd_word;
    logic [DATA_W-1:0] oreg;
    logic              ovalid;
    logic              drv_int;

    nbt_cmd_gen u_cmd (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .ilv   (ilv_order),
        .en0_n (en0_n),
        .en1   (en1),
        .en2_n (en2_n),
        .adv   (adv),
        .wr    (wr),
        .addr  (addr),
        .ben   (ben),
        .cmd   (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '0;
            s2     <= '0;
            ovalid <= 1'b0;
            oreg   <= '0;
        end else begin
            s1     <= cmd;
            s2     <= s1;
            ovalid <= s1.vld && !s1.wr;
            if (s1.vld && !s1.wr) oreg <= fwd_word;
        end
    end

    // Late write: one edge behind in flow-through, two in pipelined.
    assign wstage = flow_mode ? s1 : s2;

    nbt_array u_arr (
        .clk   (clk),
        .we    (wstage.vld && wstage.wr),
        .waddr (wstage.addr),
        .wben  (wstage.ben),
        .wdata (wdata),
        .raddr (s1.addr),
        .rword (rword)
    );

    // Pipelined read registers while the previous write's data is on the bus.
    always_comb begin
        fwd_word = rword;
        if (s2.vld && s2.wr && (s2.addr == s1.addr))
            fwd_word = lane_merge(rword, wdata, s2.ben);
    end

    assign drv_int = flow_mode ? (s1.vld && !s1.wr) : ovalid;
    assign rdrive  = drv_int && !oe_n && !sleep;
    assign rdata   = rdrive ? (flow_mode ? rword : oreg) : '0;

    AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !s1.vld); // R12
    AST_PIPE_READ_LAT: assert property (@(posedge clk) disable iff (rst)
        (!flow_mode && cmd.vld && !cmd.wr) |-> ##2 ovalid); // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!ovalid && !s1.vld)); // R1
endmodule

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;
    import nbt_pkg::*;

    localparam int CLK_P = 10;
    localparam logic [2:0] SEL   = 3'b010;
    localparam logic [2:0] NOSEL = 3'b101;
    localparam logic [3:0] FULL  = 4'hF;

    logic              clk = 1'b0;
    logic              rst, flow_mode, ilv_order, en0_n, en1, en2_n;
    logic              adv, wr, oe_n, sleep;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  ben;
    logic [DATA_W-1:0] wdata, rdata;
    logic              rdrive;
    logic [DATA_W-1:0] sched [3];
    int checks = 0;
    int fails  = 0;

    localparam logic [DATA_W-1:0] D1 = 36'h1_1111_1111, D2 = 36'h2_2222_2222;
    localparam logic [DATA_W-1:0] X5 = 36'h1_2345_6789, Y5 = 36'hF_EDCB_A987;
    localparam logic [DATA_W-1:0] A6 = 36'h6_6660_0066, A7 = 36'h7_7007_7007;
    localparam logic [DATA_W-1:0] D9 = 36'h9_0909_0909, W3 = 36'h3_0303_0303;
    localparam logic [DATA_W-1:0] ZZ = 36'hD_EADB_EEF0;
    localparam logic [DATA_W-1:0] B0 = 36'hA_0000_00A0, B1 = 36'hA_1111_11A1;
    localparam logic [DATA_W-1:0] B2 = 36'hA_2222_22A2, B3 = 36'hA_3333_33A3;

    always #(CLK_P/2) clk = ~clk;

    nbt_sram u_dut (
        .clk(clk), .rst(rst), .flow_mode(flow_mode), .ilv_order(ilv_order),
        .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .adv(adv), .wr(wr),
        .addr(addr), .ben(ben), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rdrive(rdrive)
    );

    function automatic logic [DATA_W-1:0] exp_merge(input logic [DATA_W-1:0] o,
            input logic [DATA_W-1:0] n, input logic [LANES-1:0] be);
        logic [DATA_W-1:0] r = o;
        for (int i = 0; i < LANES; i++)
            if (be[i]) r[i*LANE_W +: LANE_W] = n[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp_drv, input logic [DATA_W-1:0] exp_d);
        checks++;
        if (rdrive !== exp_drv || (exp_drv && rdata !== exp_d)) begin
            fails++;
            $display("FAIL %s rdrive=%b rdata=%h expected rdrive=%b rdata=%h",
                     req, rdrive, rdata, exp_drv, exp_d);
        end
    endtask

    task automatic issue(input logic a_adv, input logic a_wr, input logic [ADDR_W-1:0] a,
            input logic [LANES-1:0] be, input logic [2:0] en, input logic dv,
            input logic [DATA_W-1:0] d);
        adv = a_adv; wr = a_wr; addr = a; ben = be;
        {en0_n, en1, en2_n} = en;
        wdata = sched[0];
        if (dv) sched[flow_mode ? 1 : 2] = d;
        step();
        sched[0] = sched[1]; sched[1] = sched[2]; sched[2] = 36'h5_5555_5555;
    endtask

    task automatic wr_op(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
            input logic [DATA_W-1:0] d);
        issue(1'b0, 1'b1, a, be, SEL, 1'b1, d);
    endtask
    task automatic rd_op(input logic [ADDR_W-1:0] a);
        issue(1'b0, 1'b0, a, FULL, SEL, 1'b0, '0);
    endtask
    task automatic nop();
        issue(1'b0, 1'b0, '0, '0, NOSEL, 1'b0, '0);
    endtask
    // Advance beat: drives the opposite direction and a foreign address (R10).
    task automatic adv_op(input logic dv, input logic [DATA_W-1:0] d);
        issue(1'b1, !dv, 6'h3F, FULL, NOSEL, dv, d);
    endtask

    task automatic do_reset(input logic f, input logic o);
        flow_mode = f; ilv_order = o; rst = 1'b1; oe_n = 1'b0; sleep = 1'b0;
        adv = 1'b0; wr = 1'b0; addr = '0; ben = '0; wdata = '0;
        {en0_n, en1, en2_n} = NOSEL;
        for (int i = 0; i < 3; i++) sched[i] = 36'h5_5555_5555;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk("R1 after reset", 1'b0, '0);
        nop(); nop();
        chk("R1 idle after reset", 1'b0, '0);
    endtask

    task automatic t_pipe();
        wr_op(6'd1, FULL, D1);
        wr_op(6'd2, FULL, D2);
        nop(); nop();
        rd_op(6'd1);
        chk("R2 not yet driven", 1'b0, '0);
        rd_op(6'd2);
        chk("R2 R4 first read", 1'b1, D1);
        nop();
        chk("R2 R4 second read", 1'b1, D2);
        nop();
        chk("R2 released", 1'b0, '0);
    endtask

    task automatic t_b2b();
        wr_op(6'd5, FULL, X5);
        rd_op(6'd5);
        wr_op(6'd5, 4'b0010, Y5);
        chk("R5 read after write", 1'b1, X5);
        rd_op(6'd5);
        nop();
        chk("R6 forwarded merge", 1'b1, exp_merge(X5, Y5, 4'b0010));
        rd_op(6'd5);
        nop();
        chk("R6 stored merge", 1'b1, exp_merge(X5, Y5, 4'b0010));
        wr_op(6'd6, FULL, A6);
        wr_op(6'd7, FULL, A7);
        rd_op(6'd6);
        rd_op(6'd7);
        chk("R5 write write read", 1'b1, A6);
        nop();
        chk("R5 forward second", 1'b1, A7);
    endtask

    task automatic t_flow();
        do_reset(1'b1, 1'b0);
        rd_op(6'd5);
        chk("R1 contents kept", 1'b1, exp_merge(X5, Y5, 4'b0010));
        wr_op(6'd9, FULL, D9);
        rd_op(6'd9);
        chk("R3 R4 flow read", 1'b1, D9);
        nop();
        chk("R3 released", 1'b0, '0);
    endtask

    task automatic t_ce();
        wr_op(6'd3, FULL, W3);
        issue(1'b0, 1'b1, 6'd3, FULL, 3'b110, 1'b1, ZZ);
        issue(1'b0, 1'b1, 6'd3, FULL, 3'b000, 1'b1, ZZ);
        issue(1'b0, 1'b1, 6'd3, FULL, 3'b011, 1'b1, ZZ);
        rd_op(6'd3);
        chk("R7 deselected writes dropped", 1'b1, W3);
        issue(1'b0, 1'b0, 6'd3, FULL, 3'b000, 1'b0, '0);
        chk("R7 deselected read", 1'b0, '0);
    endtask

    task automatic t_lin();
        wr_op(6'h11, FULL, B0);
        adv_op(1'b1, B1);
        adv_op(1'b1, B2);
        adv_op(1'b1, B3);
        rd_op(6'h11); chk("R8 beat0", 1'b1, B0);
        rd_op(6'h12); chk("R8 beat1", 1'b1, B1);
        rd_op(6'h13); chk("R8 beat2", 1'b1, B2);
        rd_op(6'h10); chk("R8 beat3 wrap", 1'b1, B3);
        rd_op(6'h12); chk("R10 read burst start", 1'b1, B1);
        adv_op(1'b0, '0); chk("R10 read beat1", 1'b1, B2);
        adv_op(1'b0, '0); chk("R10 read beat2", 1'b1, B3);
        adv_op(1'b0, '0); chk("R10 read beat3", 1'b1, B0);
        adv_op(1'b0, '0); chk("R8 fifth beat wraps", 1'b1, B1);
    endtask

    task automatic t_ilv();
        do_reset(1'b1, 1'b1);
        rd_op(6'h11); chk("R9 beat0", 1'b1, B0);
        adv_op(1'b0, '0); chk("R9 beat1", 1'b1, B3);
        adv_op(1'b0, '0); chk("R9 beat2", 1'b1, B2);
        adv_op(1'b0, '0); chk("R9 beat3", 1'b1, B1);
        adv_op(1'b0, '0); chk("R9 wrap", 1'b1, B0);
    endtask

    task automatic t_oe();
        rd_op(6'h11);
        oe_n = 1'b1; #1;
        chk("R11 drivers off", 1'b0, '0);
        oe_n = 1'b0; #1;
        chk("R11 drivers back", 1'b1, B0);
    endtask

    task automatic t_sleep();
        sleep = 1'b1;
        wr_op(6'h11, FULL, ZZ);
        rd_op(6'h11);
        chk("R12 no drive asleep", 1'b0, '0);
        nop();
        sleep = 1'b0;
        rd_op(6'h11);
        chk("R12 contents kept", 1'b1, B0);
    endtask

    initial begin
        #(CLK_P * 50000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_pipe();
        t_b2b();
        t_flow();
        t_ce();
        t_lin();
        t_ilv();
        t_oe();
        t_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule